// File: doc/BRIEF.md
# Phase-shifted full-bridge PWM generator

This block drives the four switches of a full-bridge power stage from a digital sawtooth counter. The first half-bridge leg (outputs A and B) flips its state once per counter cycle. The second leg (outputs C and D) takes over the first leg's state after a delay. That delay is set by a duty command, so the two legs run at the same frequency with a controllable phase offset between them. The offset between the legs sets how much energy the converter transfers.

Each leg inserts its own dead time between the turn-off of one switch and the turn-on of its partner. The dead time follows a programmable code per leg. It shrinks as a load-current code rises, so that resonant transitions stay well placed from light to heavy load. An adaptive-set code controls how strongly the load current shortens the dead time. An external sync pulse ends the running cycle at once and restarts the ramp. The enable input stops and restarts the whole generator in a known phase.

Top module: `psfb_pwm`

## Requirements
- R1: While reset is asserted (synchronous, active low), all four drive outputs and the cycle pulse are low at the next clock edge.
- R2: A cycle lasts period+1 clocks. The first-leg command toggles at every cycle end, so output A has a period of 2*(period+1) clocks.
- R3: A and B are never high together, and C and D are never high together.
- R4: With equal dead times on both legs, each edge of C lags the matching edge of A by min(duty, period)+1 clocks. A duty command of 0 gives a lag of 1 clock. Any command at or above the period gives a lag of period+1 clocks, which is half of A's period.
- R5: After a leg's command changes, both outputs of that leg stay low for exactly L clocks, and then the output selected by the new command goes high. L = floor(code*2K / (3*diff + 2K)) + OFS, where diff = max(current − adaptive, 0), K = CUR_ONE current codes per unit and OFS = DT_OFS. Each leg uses its own code.
- R6: If the adaptive code is equal to or greater than the current code, L = code + OFS regardless of load. With the adaptive code at 0 and the current code at 2K, the load-dependent part of L is one quarter of its no-load value.
- R7: A dead-time code of all ones gives L = 0. In steady state that leg's two outputs are exact complements in every clock.
- R8: With enable low at a clock edge, all four outputs are low after that edge. After enable returns high, A and C turn on in the same clock when both legs have equal dead times, and B and D stay low.
- R9: A sync pulse that is high at a clock edge ends the running cycle: the cycle pulse is high after that edge, and the next natural cycle end follows period+1 clocks later.
- R10: The duty command is taken in only at cycle ends. A change in mid-cycle does not move the current cycle's C/D edges.
- R11: The cycle pulse is high for one clock at each cycle end. In free-running operation the pulses are period+1 clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Generator enable; low forces all outputs off |
| sync_i | input | 1 | External sync pulse; ends the current cycle |
| period_i | input | CNT_W | Ramp terminal count (cycle = period_i+1 clocks) |
| duty_i | input | CNT_W | Phase-shift command in clocks |
| dt_ab_i | input | DT_W | Dead-time code, first leg (all ones = none) |
| dt_cd_i | input | DT_W | Dead-time code, second leg (all ones = none) |
| cur_i | input | CUR_W | Load-current code |
| ads_i | input | CUR_W | Adaptive-set code (no modulation when at or above cur_i) |
| out_a | output | 1 | First leg, high-side command |
| out_b | output | 1 | First leg, low-side command |
| out_c | output | 1 | Second leg, high-side command |
| out_d | output | 1 | Second leg, low-side command |
| cycle_o | output | 1 | One-clock pulse at each cycle end |

## Verification
A corrupted ramp count or a stale latched period shows up within one cycle as a wrong spacing of cycle pulses and a wrong A period. A corrupted duty latch moves the next C/D edge by the error, so the C-to-A lag is wrong within half an A period. A dead-time counter that is off by one changes the length of the both-low window at the next leg transition. A deadband stage that holds a wrong state can drive both switches of a leg high, and the exclusivity checks flag that in the clock it happens. The bench compares all five outputs with a behavioural model on every clock, so any of these faults is reported in the first cycle in which it reaches a port.

// File: rtl/psfb_pkg.sv
// Shared types and constants for the phase-shifted bridge generator.
// Assumes exactly two bridge legs; index 0 is the leading leg (A/B),
// index 1 the phase-shifted leg (C/D).
package psfb_pkg;

    localparam int NUM_LEGS = 2;
    localparam int LEG_LEAD = 0;
    localparam int LEG_LAG  = 1;

    // Drive pair of one half-bridge leg
    typedef struct packed {
        logic hi;   // high-side switch command
        logic lo;   // low-side switch command
    } leg_drive_t;

endpackage

// File: rtl/psfb_ramp.sv
// Sawtooth ramp counter with cycle-boundary latching.
// Counts 0..per_q and wraps; an external sync forces the wrap early.
// Period and duty are captured only at a wrap (or while idle) so that
// downstream comparisons never see a mid-cycle change.
// Assumes: synchronous active-low reset; en_i low holds the ramp idle.
module psfb_ramp #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] duty_o,
    output logic             tick_o,
    output logic             cycle_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] duty_q;
    logic             cyc_q;
    logic             wrap;

    // Cycle end: terminal count reached or external sync
    always_comb begin
        wrap = (cnt_q == per_q) || sync_i;
    end

    // Ramp count, boundary latches and cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            per_q  <= period_i;
            duty_q <= duty_i;
            cyc_q  <= 1'b0;
        end else begin
            cyc_q <= wrap;
            if (wrap) begin
                cnt_q  <= '0;
                per_q  <= period_i;
                duty_q <= duty_i;
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign per_o   = per_q;
    assign duty_o  = duty_q;
    assign tick_o  = wrap;
    assign cycle_o = cyc_q;

endmodule

// File: rtl/psfb_phase.sv
// Leg command generator. The leading-leg command flips at every ramp wrap.
// The lagging-leg command copies the leading one when the ramp equals the
// latched duty (clamped to the period), which yields a lag of duty+1 clocks.
// Assumes cnt_i never exceeds per_i (guaranteed by psfb_ramp).
module psfb_phase
    import psfb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                tick_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [CNT_W-1:0]    per_i,
    input  logic [CNT_W-1:0]    duty_i,
    output logic [NUM_LEGS-1:0] cmd_o
);

    logic [CNT_W-1:0] duty_eff;
    logic             lead_q;
    logic             lag_q;
    logic             hit;

    // Clamp the shift to a half period and detect the ramp crossing
    always_comb begin
        duty_eff = (duty_i > per_i) ? per_i : duty_i;
        hit      = (cnt_i == duty_eff);
    end

    // Leading toggle and lagging copy; idle restarts both legs high
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            lead_q <= 1'b1;
            lag_q  <= 1'b1;
        end else begin
            if (tick_i) begin
                lead_q <= ~lead_q;
            end
            if (hit) begin
                lag_q <= lead_q;
            end
        end
    end

    assign cmd_o[LEG_LEAD] = lead_q;
    assign cmd_o[LEG_LAG]  = lag_q;

endmodule

// File: rtl/psfb_dt_scale.sv
// Load-adaptive dead-time length.
// len = floor(code*2K / (3*diff + 2K)) + DT_OFS, with diff = max(cur-ads,0)
// and K = CUR_ONE current codes per unit; this is code scaled by
// 0.5 / (0.75*diff/K + 0.5). An all-ones code yields zero (no dead time).
// Purely combinational; assumes the result fits LEN_W bits.
module psfb_dt_scale #(
    parameter int DT_W    = 6,
    parameter int CUR_W   = 6,
    parameter int CUR_ONE = 8,
    parameter int DT_OFS  = 1,
    parameter int LEN_W   = 8
) (
    input  logic [DT_W-1:0]  code_i,
    input  logic [CUR_W-1:0] cur_i,
    input  logic [CUR_W-1:0] ads_i,
    output logic [LEN_W-1:0] len_o
);

    localparam int CW = DT_W + CUR_W + 8;

    logic [CW-1:0] diff;
    logic [CW-1:0] num;
    logic [CW-1:0] den;
    logic [CW-1:0] quot;

    // Divisor from load headroom, then scaled length plus fixed offset
    always_comb begin
        diff = (cur_i > ads_i) ? CW'(cur_i - ads_i) : '0;
        num  = CW'(code_i) * CW'(2 * CUR_ONE);
        den  = CW'(3) * diff + CW'(2 * CUR_ONE);
        quot = num / den;
        if (&code_i) begin
            len_o = '0;
        end else begin
            len_o = LEN_W'(quot) + LEN_W'(DT_OFS);
        end
    end

endmodule

// File: rtl/psfb_deadband.sv
// Dead-band stage for one leg. On a command change both switches are
// turned off for len_i clocks, then the commanded side is turned on.
// len_i of zero switches both sides in the same clock. While idle the
// stage is off and primed so that restart also waits out the dead time.
// Assumes len_i may change at any clock; it is sampled at command changes.
module psfb_deadband
    import psfb_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cmd_i,
    input  logic [LEN_W-1:0] len_i,
    output leg_drive_t       drv_o
);

    logic             cmd_d;
    logic             wait_q;
    logic [LEN_W-1:0] cnt_q;
    leg_drive_t       drv_q;

    // Off-window countdown and drive update
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            drv_q  <= '0;
            cmd_d  <= cmd_i;
            wait_q <= 1'b1;
            cnt_q  <= (len_i == '0) ? '0 : len_i - LEN_W'(1);
        end else if (cmd_i != cmd_d) begin
            cmd_d <= cmd_i;
            if (len_i == '0) begin
                drv_q.hi <= cmd_i;
                drv_q.lo <= ~cmd_i;
                wait_q   <= 1'b0;
            end else begin
                drv_q  <= '0;
                cnt_q  <= len_i - LEN_W'(1);
                wait_q <= 1'b1;
            end
        end else if (wait_q) begin
            if (cnt_q == '0) begin
                drv_q.hi <= cmd_i;
                drv_q.lo <= ~cmd_i;
                wait_q   <= 1'b0;
            end else begin
                cnt_q <= cnt_q - LEN_W'(1);
            end
        end
    end

    assign drv_o = drv_q;

endmodule

// File: rtl/psfb_pwm.sv
// Phase-shifted full-bridge PWM generator (top).
// Ramp -> leg commands -> per-leg adaptive dead-band -> four drives.
// Assumes synchronous active-low reset and a sync pulse in the clk domain.
module psfb_pwm
    import psfb_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DT_W    = 6,
    parameter int CUR_W   = 6,
    parameter int CUR_ONE = 8,
    parameter int DT_OFS  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DT_W-1:0]  dt_ab_i,
    input  logic [DT_W-1:0]  dt_cd_i,
    input  logic [CUR_W-1:0] cur_i,
    input  logic [CUR_W-1:0] ads_i,
    output logic             out_a,
    output logic             out_b,
    output logic             out_c,
    output logic             out_d,
    output logic             cycle_o
);

    localparam int LEN_W = DT_W + 2;

    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    per_lat;
    logic [CNT_W-1:0]    duty_lat;
    logic                tick;
    logic [NUM_LEGS-1:0] leg_cmd;
    logic [DT_W-1:0]     dt_code [NUM_LEGS];
    logic [LEN_W-1:0]    dt_len  [NUM_LEGS];
    leg_drive_t          drv     [NUM_LEGS];

    assign dt_code[LEG_LEAD] = dt_ab_i;
    assign dt_code[LEG_LAG]  = dt_cd_i;

    psfb_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .sync_i   (sync_i),
        .period_i (period_i),
        .duty_i   (duty_i),
        .cnt_o    (cnt),
        .per_o    (per_lat),
        .duty_o   (duty_lat),
        .tick_o   (tick),
        .cycle_o  (cycle_o)
    );

    psfb_phase #(.CNT_W(CNT_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .tick_i (tick),
        .cnt_i  (cnt),
        .per_i  (per_lat),
        .duty_i (duty_lat),
        .cmd_o  (leg_cmd)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        psfb_dt_scale #(
            .DT_W    (DT_W),
            .CUR_W   (CUR_W),
            .CUR_ONE (CUR_ONE),
            .DT_OFS  (DT_OFS),
            .LEN_W   (LEN_W)
        ) u_scale (
            .code_i (dt_code[g]),
            .cur_i  (cur_i),
            .ads_i  (ads_i),
            .len_o  (dt_len[g])
        );

        psfb_deadband #(.LEN_W(LEN_W)) u_band (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (en_i),
            .cmd_i (leg_cmd[g]),
            .len_i (dt_len[g]),
            .drv_o (drv[g])
        );
    end

    assign out_a = drv[LEG_LEAD].hi;
    assign out_b = drv[LEG_LEAD].lo;
    assign out_c = drv[LEG_LAG].hi;
    assign out_d = drv[LEG_LAG].lo;

endmodule

// File: rtl/psfb_pwm_chk.sv
// Property checker for psfb_pwm, attached by bind below.
module psfb_pwm_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             sync_i,
    input logic             out_a,
    input logic             out_b,
    input logic             out_c,
    input logic             out_d,
    input logic             cycle_o,
    input logic             tick,
    input logic [CNT_W-1:0] duty_lat
);

    AST_AB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_b));                                          // R3
    AST_CD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_c && out_d));                                          // R3
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !(out_a || out_b || out_c || out_d));              // R8
    AST_SYNC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sync_i) |=> cycle_o);                               // R9
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick) |=> $stable(duty_lat));                      // R10

endmodule

bind psfb_pwm psfb_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .sync_i   (sync_i),
    .out_a    (out_a),
    .out_b    (out_b),
    .out_c    (out_c),
    .out_d    (out_d),
    .cycle_o  (cycle_o),
    .tick     (tick),
    .duty_lat (duty_lat)
);

// File: tb/sim_psfb_pwm.sv
// Bench for psfb_pwm: behavioural per-clock model plus directed measurements.
module sim_psfb_pwm;

    localparam int CNT_W = 8, DT_W = 6, CUR_W = 6, CUR_ONE = 8, DT_OFS = 1;
    localparam int ALL1 = (1 << DT_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0, en_i = 1'b0, sync_i = 1'b0;
    logic [CNT_W-1:0] period_i = 8'd19, duty_i = 8'd5;
    logic [DT_W-1:0]  dt_ab_i = 6'd4, dt_cd_i = 6'd4;
    logic [CUR_W-1:0] cur_i = '0, ads_i = '0;
    logic out_a, out_b, out_c, out_d, cycle_o;

    always #4 clk = ~clk;   // 125 MHz

    psfb_pwm #(.CNT_W(CNT_W), .DT_W(DT_W), .CUR_W(CUR_W),
               .CUR_ONE(CUR_ONE), .DT_OFS(DT_OFS)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .sync_i(sync_i),
        .period_i(period_i), .duty_i(duty_i), .dt_ab_i(dt_ab_i),
        .dt_cd_i(dt_cd_i), .cur_i(cur_i), .ads_i(ads_i),
        .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d),
        .cycle_o(cycle_o));

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_per, m_duty, m_cyc, m_ab, m_cd;
    int m_cmdd [2], m_wait [2], m_dc [2], m_p [2], m_n [2];

    function automatic int dead_len(input int code);
        int diff;
        diff = (int'(cur_i) > int'(ads_i)) ? int'(cur_i) - int'(ads_i) : 0;
        if (code == ALL1) return 0;
        return (code * 2 * CUR_ONE) / (3 * diff + 2 * CUR_ONE) + DT_OFS;
    endfunction

    always @(posedge clk) begin
        int len [2];
        int cmd [2];
        int tk, deff;
        len[0] = dead_len(int'(dt_ab_i));
        len[1] = dead_len(int'(dt_cd_i));
        cmd[0] = m_ab;
        cmd[1] = m_cd;
        if (!rst_n || !en_i) begin
            for (int i = 0; i < 2; i++) begin
                m_p[i] = 0; m_n[i] = 0; m_cmdd[i] = cmd[i]; m_wait[i] = 1;
                m_dc[i] = (len[i] == 0) ? 0 : len[i] - 1;
            end
            m_cnt = 0; m_per = int'(period_i); m_duty = int'(duty_i);
            m_cyc = 0; m_ab = 1; m_cd = 1;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (cmd[i] != m_cmdd[i]) begin
                    m_cmdd[i] = cmd[i];
                    if (len[i] == 0) begin
                        m_p[i] = cmd[i]; m_n[i] = 1 - cmd[i]; m_wait[i] = 0;
                    end else begin
                        m_p[i] = 0; m_n[i] = 0; m_dc[i] = len[i] - 1; m_wait[i] = 1;
                    end
                end else if (m_wait[i] != 0) begin
                    if (m_dc[i] == 0) begin
                        m_p[i] = cmd[i]; m_n[i] = 1 - cmd[i]; m_wait[i] = 0;
                    end else m_dc[i]--;
                end
            end
            tk   = (m_cnt == m_per || sync_i) ? 1 : 0;
            deff = (m_duty > m_per) ? m_per : m_duty;
            if (m_cnt == deff) m_cd = cmd[0];
            if (tk != 0) m_ab = 1 - cmd[0];
            m_cyc = tk;
            if (tk != 0) begin
                m_cnt = 0; m_per = int'(period_i); m_duty = int'(duty_i);
            end else m_cnt++;
        end
    end

    // ---------------- per-clock compare and measurements ----------------
    int tnow = 0, t_rise_a = 0, t_fall_a = 0, t_rise_c = 0, t_cyc = 0;
    int a_per = 0, c_lag = 0, cyc_gap = 0;
    int run_ab = 0, run_cd = 0, ab_dead = -1, cd_dead = -1;
    int both_hi = 0, eq_ab = 0;
    bit mon_eq = 0;
    logic pa = 0, pc = 0;

    always @(negedge clk) begin
        tnow++;
        chk(out_a == m_p[0][0] && out_b == m_n[0][0], "R2 model A/B",
            {out_a, out_b}, {m_p[0][0], m_n[0][0]});
        chk(out_c == m_p[1][0] && out_d == m_n[1][0], "R4 model C/D",
            {out_c, out_d}, {m_p[1][0], m_n[1][0]});
        chk(cycle_o == m_cyc[0], "R11 model cycle", cycle_o, m_cyc);
        if ((out_a && out_b) || (out_c && out_d)) both_hi++;
        if (mon_eq && (out_a == out_b)) eq_ab++;
        if (out_a && !pa) begin a_per = tnow - t_rise_a; t_rise_a = tnow; end
        if (!out_a && pa) t_fall_a = tnow;
        if (out_c && !pc) begin c_lag = tnow - t_rise_a; t_rise_c = tnow; end
        if (!out_c && pc) c_lag = tnow - t_fall_a;
        if (!out_a && !out_b) run_ab++;
        else begin if (run_ab > 0) ab_dead = run_ab; run_ab = 0; end
        if (!out_c && !out_d) run_cd++;
        else begin if (run_cd > 0) cd_dead = run_cd; run_cd = 0; end
        if (cycle_o) begin cyc_gap = tnow - t_cyc; t_cyc = tnow; end
        pa = out_a; pc = out_c;
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        int t_en;
        wait_n(3);
        chk({out_a, out_b, out_c, out_d, cycle_o} == 5'b0, "R1 reset outputs",
            {out_a, out_b, out_c, out_d, cycle_o}, 0);
        rst_n = 1; en_i = 1;
        wait_n(200);                                   // L = 4+1 = 5
        chk(a_per == 40, "R2 A period", a_per, 40);
        chk(c_lag == 6, "R4 lag duty 5", c_lag, 6);
        chk(ab_dead == 5, "R5 AB dead", ab_dead, 5);
        chk(cd_dead == 5, "R5 CD dead", cd_dead, 5);
        chk(cyc_gap == 20, "R11 cycle spacing", cyc_gap, 20);

        dt_ab_i = 8; dt_cd_i = 8; wait_n(120);         // no load: 8+1
        chk(ab_dead == 9, "R6 light load", ab_dead, 9);
        cur_i = 16; wait_n(120);                       // 8*16/64+1 = 3
        chk(ab_dead == 3, "R6 heavy load", ab_dead, 3);
        chk(cd_dead == 3, "R5 CD heavy load", cd_dead, 3);
        chk((9 - DT_OFS) == 4 * (ab_dead - DT_OFS), "R6 ratio 4:1", ab_dead, 3);
        ads_i = 16; wait_n(120);
        chk(ab_dead == 9, "R6 ads equals cur", ab_dead, 9);
        ads_i = 30; wait_n(120);
        chk(ab_dead == 9, "R6 ads above cur", ab_dead, 9);
        ads_i = 0;

        duty_i = 200; wait_n(120);
        chk(c_lag == 20, "R4 lag clamped", c_lag, 20);
        duty_i = 0; wait_n(120);
        chk(c_lag == 1, "R4 lag duty 0", c_lag, 1);
        duty_i = 5; wait_n(120);

        do wait_n(1); while (!cycle_o);                // R10 mid-cycle change
        duty_i = 15; wait_n(10);
        chk(c_lag == 6, "R10 old lag kept", c_lag, 6);
        chk(out_c == out_a, "R10 C follows A", out_c, out_a);
        wait_n(80);
        chk(c_lag == 16, "R10 new lag", c_lag, 16);

        dt_ab_i = 6'(ALL1); wait_n(40);                // R7
        mon_eq = 1; wait_n(80); mon_eq = 0;
        chk(eq_ab == 0, "R7 no dead time", eq_ab, 0);
        chk(cd_dead == 3, "R5 CD leg independent", cd_dead, 3);
        dt_ab_i = 8; wait_n(60);

        en_i = 0; wait_n(1);                           // R8
        chk({out_a, out_b, out_c, out_d} == 4'b0, "R8 idle low",
            {out_a, out_b, out_c, out_d}, 0);
        wait_n(10);
        en_i = 1; t_en = tnow; wait_n(12);
        chk(t_rise_a == t_rise_c && t_rise_a > t_en, "R8 A and C restart together",
            t_rise_c, t_rise_a);
        chk(!out_b && !out_d, "R8 B D low on restart", {out_b, out_d}, 0);
        wait_n(60);

        do wait_n(1); while (!cycle_o);                // R9
        wait_n(7); sync_i = 1; wait_n(1);
        chk(cycle_o == 1'b1, "R9 sync ends cycle", cycle_o, 1);
        chk(cyc_gap == 8, "R9 short cycle", cyc_gap, 8);
        sync_i = 0; wait_n(25);
        chk(cyc_gap == 20, "R9 restart spacing", cyc_gap, 20);
        chk(both_hi == 0, "R3 leg exclusivity", both_hi, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule